// File: doc/BRIEF.md
# Gate-Qualified Event Counter

This block is an up-counter that advances by one on every tick of a count clock. The tick is presented as a one-cycle strobe in the system clock domain. A separate gate input decides when ticks are counted. A 4-bit mode selects how the gate is used:

- no gate at all;
- start on the first gate edge;
- count only while the gate is at a level;
- count during a single pulse width or a single period bounded by gate edges.

Counting begins from a programmed start value. That value is loaded, and all run state is cleared, whenever the enable input is low.

When the counter steps past its all-ones value it raises a sticky overflow flag. A policy input then picks one of two behaviours:

- **Stop:** the count freezes at all-ones and the output pin is driven high.
- **Keep counting:** the count reloads the start value and the output pin toggles on every overflow.

Before the first overflow, the output pin shows a programmable idle level. The gate is synchronised and edge-detected in the system clock domain before the mode logic uses it.

Top module: `gate_event_counter`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `count` equals `start_val` (0 during reset), `ovf` is 0 and `out_pin` equals `idle_lvl`. Dropping `enable` clears an overflow and any finished one-shot run.
- R2: Mode code 0 counts every tick regardless of the gate.
- R3: Mode code 1 starts counting at the first gate rising edge seen after enable, and code 2 at the first falling edge. A gate already at a level when enable rises is not an edge. Once started, gate activity has no effect.
- R4: Mode code 3 counts ticks only while the gate is high and holds the count while it is low, resuming from the held value. Code 4 is the same with the gate inverted.
- R5: Mode code 5 counts from a gate rising edge to the following falling edge and code 6 from a falling edge to the following rising edge. After that the count never changes until re-enabled.
- R6: Mode code 7 counts from a gate rising edge to the next rising edge and code 8 from a falling edge to the next falling edge. After that the count never changes until re-enabled.
- R7: The count changes only on a tick, and by exactly +1 unless an overflow occurs.
- R8: With `wrap_en`=0, a tick at count all-ones sets `ovf`=1, leaves the count at all-ones, drives `out_pin` high, and all later ticks are ignored.
- R9: With `wrap_en`=1, a tick at count all-ones sets `ovf`=1 and reloads `start_val`. `out_pin` is high after the 1st, 3rd, 5th… overflow and low after the 2nd, 4th….
- R10: Mode codes 9 to 15 never count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per count-clock rising edge |
| gate_in | input | 1 | Asynchronous gate signal |
| enable | input | 1 | Run enable; low loads the start value |
| start_val | input | CNT_W | Programmed start value |
| mode | input | 4 | Gate qualification mode code, 0 to 8 |
| wrap_en | input | 1 | Overflow policy: 1 keep counting, 0 stop |
| idle_lvl | input | 1 | Output pin level before the first overflow |
| count | output | CNT_W | Live count value |
| ovf | output | 1 | Sticky overflow flag |
| out_pin | output | 1 | Counter output pin |

## Verification
The bench targets three kinds of corner case.

- **Gate already at its active level at enable.** A design that treated this as an edge would start mode 1 too early and count extra ticks.
- **One-shot modes.** The stopping edge is the same polarity as the starting edge in modes 7 and 8, and the opposite polarity in modes 5 and 6. A design that ended the run on the wrong edge, or re-armed after finishing, shows counts that differ from the hand-computed totals.
- **Overflow boundary.** Under both policies a design that wrapped one tick early, kept counting after a stop, or toggled the pin with the wrong phase gives a wrong count or a wrong pin level right at the all-ones step.

// File: rtl/gate_event_counter_pkg.sv
package gate_event_counter_pkg;

  typedef enum logic [1:0] {PH_ARMED, PH_RUN, PH_DONE} phase_t;

  localparam logic [3:0] M_FREE  = 4'd0;
  localparam logic [3:0] M_RISE1 = 4'd1;
  localparam logic [3:0] M_FALL1 = 4'd2;
  localparam logic [3:0] M_HIGH  = 4'd3;
  localparam logic [3:0] M_LOW   = 4'd4;
  localparam logic [3:0] M_WPOS  = 4'd5;
  localparam logic [3:0] M_WNEG  = 4'd6;
  localparam logic [3:0] M_PRISE = 4'd7;
  localparam logic [3:0] M_PFALL = 4'd8;

  // edge that moves an armed run into counting
  function automatic logic start_hit(input logic [3:0] m, input logic rise, input logic fall);
    case (m)
      M_RISE1, M_WPOS, M_PRISE: start_hit = rise;
      M_FALL1, M_WNEG, M_PFALL: start_hit = fall;
      default:                  start_hit = 1'b0;
    endcase
  endfunction

  // edge that ends a one-shot run
  function automatic logic stop_hit(input logic [3:0] m, input logic rise, input logic fall);
    case (m)
      M_WNEG, M_PRISE: stop_hit = rise;
      M_WPOS, M_PFALL: stop_hit = fall;
      default:         stop_hit = 1'b0;
    endcase
  endfunction

  function automatic logic count_allowed(input logic [3:0] m, input logic lvl, input phase_t ph);
    case (m)
      M_FREE:  count_allowed = 1'b1;
      M_HIGH:  count_allowed = lvl;
      M_LOW:   count_allowed = ~lvl;
      M_RISE1, M_FALL1, M_WPOS, M_WNEG, M_PRISE, M_PFALL:
               count_allowed = (ph == PH_RUN);
      default: count_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], gate_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  // R3
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rise, fall}));
endmodule

// File: rtl/gate_qual.sv
module gate_qual
  import gate_event_counter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [3:0] mode,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  output logic       allow
);
  phase_t phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= PH_ARMED;
    else if (!enable) phase <= PH_ARMED;
    else begin
      case (phase)
        PH_ARMED: if (start_hit(mode, rise, fall)) phase <= PH_RUN;
        PH_RUN:   if (stop_hit(mode, rise, fall))  phase <= PH_DONE;
        default:  phase <= PH_DONE;
      endcase
    end
  end

  assign allow = count_allowed(mode, lvl, phase);

  // R5
  done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_DONE) |=> (phase == PH_DONE || !$past(enable)));
  // R10
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_PFALL) |-> !allow);
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             allow,
  input  logic [CNT_W-1:0] start_val,
  input  logic             wrap_en,
  input  logic             idle_lvl,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             out_pin
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic ostate;
  logic frozen;
  logic step;
  logic at_top;

  assign frozen = ovf & ~wrap_en;
  assign step   = tick & allow & ~frozen;
  assign at_top = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ovf    <= 1'b0;
      ostate <= 1'b0;
    end else if (!enable) begin
      count  <= start_val;
      ovf    <= 1'b0;
      ostate <= 1'b0;
    end else if (step) begin
      if (at_top) begin
        ovf <= 1'b1;
        if (wrap_en) begin
          count  <= start_val;
          ostate <= ~ostate;
        end else begin
          ostate <= 1'b1;
        end
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  assign out_pin = ovf ? ostate : idle_lvl;

  // R1
  disabled_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == $past(start_val) && !ovf));
  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> (count == $past(count)));
  // R7
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && allow && !frozen && !at_top) |=> (count == $past(count) + 1'b1));
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ovf && !wrap_en) |=> (count == $past(count) && ovf));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ovf) |=> (ovf || !$past(enable)));
endmodule

// File: rtl/gate_event_counter.sv
module gate_event_counter
  import gate_event_counter_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_in,
  input  logic             enable,
  input  logic [CNT_W-1:0] start_val,
  input  logic [3:0]       mode,
  input  logic             wrap_en,
  input  logic             idle_lvl,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             out_pin
);
  logic g_lvl, g_rise, g_fall, allow;

  gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
    .lvl(g_lvl), .rise(g_rise), .fall(g_fall)
  );

  gate_qual u_qual (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .lvl(g_lvl), .rise(g_rise), .fall(g_fall), .allow(allow)
  );

  count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .allow(allow),
    .start_val(start_val), .wrap_en(wrap_en), .idle_lvl(idle_lvl),
    .count(count), .ovf(ovf), .out_pin(out_pin)
  );
endmodule

// File: tb/gate_event_counter_test.sv
module gate_event_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic gate_in = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] start_val = 24'd100;
  logic [3:0] mode = 4'd0;
  logic wrap_en = 1'b0;
  logic idle_lvl = 1'b0;
  logic [W-1:0] count;
  logic ovf, out_pin;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_event_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in), .enable(enable),
    .start_val(start_val), .mode(mode), .wrap_en(wrap_en), .idle_lvl(idle_lvl),
    .count(count), .ovf(ovf), .out_pin(out_pin)
  );

  typedef struct packed {
    logic [3:0]   md;
    logic [W-1:0] init;
    logic g0; logic [4:0] n0;
    logic g1; logic [4:0] n1;
    logic g2; logic [4:0] n2;
    logic g3; logic [4:0] n3;
    logic [W-1:0] expv;
  } vec_t;

  // per row: mode, start, then four (gate level, ticks) phases, expected count
  localparam vec_t VECS [11] = '{
    '{4'd0,  24'd100, 1'b0, 5'd3, 1'b1, 5'd2, 1'b0, 5'd4, 1'b1, 5'd1, 24'd110}, // R2
    '{4'd1,  24'd100, 1'b0, 5'd5, 1'b1, 5'd3, 1'b0, 5'd2, 1'b1, 5'd1, 24'd106}, // R3
    '{4'd2,  24'd100, 1'b1, 5'd5, 1'b0, 5'd3, 1'b1, 5'd2, 1'b0, 5'd1, 24'd106}, // R3
    '{4'd3,  24'd100, 1'b0, 5'd4, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 5'd2, 24'd105}, // R4
    '{4'd4,  24'd100, 1'b0, 5'd4, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 5'd2, 24'd109}, // R4
    '{4'd5,  24'd100, 1'b0, 5'd4, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 5'd2, 24'd103}, // R5
    '{4'd6,  24'd100, 1'b1, 5'd4, 1'b0, 5'd3, 1'b1, 5'd5, 1'b0, 5'd2, 24'd103}, // R5
    '{4'd7,  24'd100, 1'b0, 5'd4, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 5'd2, 24'd108}, // R6
    '{4'd8,  24'd100, 1'b1, 5'd4, 1'b0, 5'd3, 1'b1, 5'd5, 1'b0, 5'd2, 24'd108}, // R6
    '{4'd11, 24'd100, 1'b0, 5'd4, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 5'd2, 24'd100}, // R10
    '{4'd1,  24'd0,   1'b1, 5'd3, 1'b0, 5'd2, 1'b1, 5'd4, 1'b1, 5'd1, 24'd5}    // R3
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_gate(input logic g);
    gate_in = g;
    idle(5);
  endtask

  task automatic restart(input logic [3:0] m, input logic [W-1:0] sv, input logic g);
    enable = 1'b0;
    mode = m;
    start_val = sv;
    gate_in = g;
    idle(6);
    enable = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset count", count, 24'd0);
    rst_n = 1'b1;
    idle(2);
    check("R1 disabled load", count, 24'd100);
    check("R1 ovf clear", {23'd0, ovf}, 24'd0);
    idle_lvl = 1'b1;
    idle(1);
    check("R1 idle level high", {23'd0, out_pin}, 24'd1);
    idle_lvl = 1'b0;
    idle(1);
    check("R1 idle level low", {23'd0, out_pin}, 24'd0);

    foreach (VECS[k]) begin
      restart(VECS[k].md, VECS[k].init, VECS[k].g0);
      pulse_ticks(int'(VECS[k].n0));
      set_gate(VECS[k].g1); pulse_ticks(int'(VECS[k].n1));
      set_gate(VECS[k].g2); pulse_ticks(int'(VECS[k].n2));
      set_gate(VECS[k].g3); pulse_ticks(int'(VECS[k].n3));
      idle(2);
      check($sformatf("R2-table row %0d mode %0d (R3 R4 R5 R6 R10)", k, VECS[k].md),
            count, VECS[k].expv);
    end

    // R7: no ticks, no change
    restart(4'd0, 24'd42, 1'b0);
    idle(20);
    set_gate(1'b1);
    set_gate(1'b0);
    check("R7 hold without ticks", count, 24'd42);

    // R8: stop policy
    wrap_en = 1'b0;
    restart(4'd0, TOP - 24'd2, 1'b0);
    pulse_ticks(2);
    check("R8 reach top", count, TOP);
    check("R8 no ovf yet", {23'd0, ovf}, 24'd0);
    check("R8 pin idle before ovf", {23'd0, out_pin}, 24'd0);
    pulse_ticks(1);
    check("R8 ovf set", {23'd0, ovf}, 24'd1);
    check("R8 count held at top", count, TOP);
    check("R8 pin high", {23'd0, out_pin}, 24'd1);
    pulse_ticks(3);
    check("R8 later ticks ignored", count, TOP);

    // R1: disabling clears overflow
    enable = 1'b0;
    idle(2);
    check("R1 disable clears ovf", {23'd0, ovf}, 24'd0);
    check("R1 disable reloads", count, TOP - 24'd2);

    // R9: keep-counting policy
    wrap_en = 1'b1;
    restart(4'd0, TOP - 24'd1, 1'b0);
    pulse_ticks(1);
    check("R9 reach top", count, TOP);
    pulse_ticks(1);
    check("R9 wrap to start", count, TOP - 24'd1);
    check("R9 ovf set", {23'd0, ovf}, 24'd1);
    check("R9 pin high after first", {23'd0, out_pin}, 24'd1);
    pulse_ticks(2);
    check("R9 pin low after second", {23'd0, out_pin}, 24'd0);
    check("R9 wrap again", count, TOP - 24'd1);
    pulse_ticks(2);
    check("R9 pin high after third", {23'd0, out_pin}, 24'd1);
    pulse_ticks(1);
    check("R9 counts after wrap", count, TOP);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule